// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small microcontroller run, and when the core is held in reset. Software asks for one of two low-power modes through a pair of request strobes. In the light sleep mode the core clock is gated and the peripheral clocks keep running. In the deep sleep mode the oscillator enable is dropped, so every clock stops.

The two modes have different ways out. Light sleep ends when any pending, enabled interrupt line is seen, or when the hardware reset pin is asserted. Deep sleep ignores interrupts and ends only through the hardware reset pin. After deep sleep the oscillator restarts and the core stays in reset for a fixed settle count.

When a hardware reset ends light sleep, the core runs briefly before the internal reset takes hold. During that short window the block raises a strobe that blocks internal RAM writes, while port writes stay allowed. RAM contents are not touched by any of these transitions.

Top module: `lpm_seq`

## Requirements
- R1: While `rst_n` is low, and until the first clock after the synchronised release in which `hw_rst_i` is low, the outputs are `cpu_clk_en_o`=1, `periph_clk_en_o`=1, `osc_en_o`=1 and `core_rst_o`=1. The next cycle is the run state, with all three enables at 1, `core_rst_o`=0 and both mode flags at 0.
- R2: In the run state, `sleep_req_i`=1 with `deep_req_i`=0 and `hw_rst_i`=0 gives, from the next cycle on, `sleep_o`=1, `cpu_clk_en_o`=0, `periph_clk_en_o`=1 and `osc_en_o`=1.
- R3: In the run state, `deep_req_i`=1 with `hw_rst_i`=0 gives, from the next cycle on, `deep_o`=1 with `cpu_clk_en_o`, `periph_clk_en_o` and `osc_en_o` all at 0.
- R4: When both requests arrive in the same run cycle, the deep request wins, and `sleep_o` stays 0.
- R5: In light sleep, any set bit of `irq_pend_i` (while `hw_rst_i`=0) returns the block to the run state on the next cycle, so `sleep_o`=0 and `cpu_clk_en_o`=1.
- R6: In deep sleep, `irq_pend_i`, `sleep_req_i` and `deep_req_i` have no effect: the outputs stay at their deep sleep values until `hw_rst_i` is seen. Requests are acted on only in the run state.
- R7: `hw_rst_i` seen in deep sleep gives exactly `OSC_SETTLE` cycles with `osc_en_o`=1, `core_rst_o`=1 and the clock enables at 0. After that the block enters the run state if `hw_rst_i` is low in the last settle cycle, or otherwise the R1 reset state until `hw_rst_i` is low.
- R8: `hw_rst_i` seen in light sleep, with or without a pending interrupt, gives exactly `GRACE_CYC` cycles of `cpu_clk_en_o`=1, `core_rst_o`=0 and `ram_wr_block_o`=1. These are followed by at least one cycle of `core_rst_o`=1 with `ram_wr_block_o`=0.
- R9: `hw_rst_i` seen in the run state gives `core_rst_o`=1 on the next cycle with all enables at 1. `core_rst_o` returns to 0 on the cycle after `hw_rst_i` is seen low.
- R10: `sleep_o` and `deep_o` are never 1 together, and `ram_wr_block_o` is 1 only in the R8 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset, released synchronously inside |
| sleep_req_i | input | 1 | Software strobe requesting light sleep |
| deep_req_i | input | 1 | Software strobe requesting deep sleep |
| irq_pend_i | input | NIRQ | Pending and enabled interrupt lines |
| hw_rst_i | input | 1 | Synchronised hardware reset pin level |
| cpu_clk_en_o | output | 1 | Core clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Internal reset request to core and registers |
| ram_wr_block_o | output | 1 | Blocks internal RAM writes |
| sleep_o | output | 1 | Light sleep mode flag |
| deep_o | output | 1 | Deep sleep mode flag |

## Verification
Every output is decoded from registered state, so the effect of an input sampled at one rising edge shows in the very next cycle. The only longer delays are the settle and grace windows. Those last exactly `OSC_SETTLE` and `GRACE_CYC` cycles from the edge at which `hw_rst_i` was sampled. The bench drives inputs at a falling edge, advances its own model by one step for the rising edge that follows, and compares all outputs at the next falling edge, so each check lands in the cycle the result is due.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_DEEP  = 3'd2,
    ST_WAKE  = 3'd3,
    ST_GRACE = 3'd4,
    ST_HOLD  = 3'd5
  } lpm_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic osc_en;
    logic core_rst;
    logic ram_blk;
    logic sleep;
    logic deep;
  } lpm_ctl_s;

endpackage

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int OSC_SETTLE = 8,
  parameter int GRACE_CYC  = 2,
  parameter int W          = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_req,
  input  logic         deep_req,
  input  logic         irq_any,
  input  logic         hw_rst,
  input  logic         tmr_done,
  output lpm_state_e   state,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val
);

  localparam logic [W-1:0] SETTLE_LD = W'(OSC_SETTLE - 1);
  localparam logic [W-1:0] GRACE_LD  = W'(GRACE_CYC - 1);

  lpm_state_e st_q;
  lpm_state_e st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_RUN: begin
        if (hw_rst)         st_d = ST_HOLD;
        else if (deep_req)  st_d = ST_DEEP;
        else if (sleep_req) st_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (hw_rst) begin
          st_d     = ST_GRACE;
          tmr_load = 1'b1;
          tmr_val  = GRACE_LD;
        end else if (irq_any) begin
          st_d = ST_RUN;
        end
      end
      ST_DEEP: begin
        if (hw_rst) begin
          st_d     = ST_WAKE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
      end
      ST_WAKE: begin
        if (tmr_done) st_d = hw_rst ? ST_HOLD : ST_RUN;
      end
      ST_GRACE: begin
        if (tmr_done) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!hw_rst) st_d = ST_RUN;
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  output lpm_ctl_s   ctl
);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_RUN:   begin ctl.cpu_en = 1'b1; ctl.per_en = 1'b1; ctl.osc_en = 1'b1; end
      ST_SLEEP: begin ctl.per_en = 1'b1; ctl.osc_en = 1'b1; ctl.sleep = 1'b1; end
      ST_DEEP:  begin ctl.deep = 1'b1; end
      ST_WAKE:  begin ctl.osc_en = 1'b1; ctl.core_rst = 1'b1; end
      ST_GRACE: begin
        ctl.cpu_en  = 1'b1;
        ctl.per_en  = 1'b1;
        ctl.osc_en  = 1'b1;
        ctl.ram_blk = 1'b1;
      end
      ST_HOLD:  begin
        ctl.cpu_en   = 1'b1;
        ctl.per_en   = 1'b1;
        ctl.osc_en   = 1'b1;
        ctl.core_rst = 1'b1;
      end
      default:  begin ctl.osc_en = 1'b1; ctl.core_rst = 1'b1; end
    endcase
  end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int OSC_SETTLE = 8,
  parameter int GRACE_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req_i,
  input  logic            deep_req_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic            hw_rst_i,
  output logic            cpu_clk_en_o,
  output logic            periph_clk_en_o,
  output logic            osc_en_o,
  output logic            core_rst_o,
  output logic            ram_wr_block_o,
  output logic            sleep_o,
  output logic            deep_o
);

  localparam int MAXC = (OSC_SETTLE > GRACE_CYC) ? OSC_SETTLE : GRACE_CYC;
  localparam int W    = $clog2(MAXC + 1);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        irq_any;
  logic        tmr_load;
  logic        tmr_done;
  logic [W-1:0] tmr_val;
  lpm_state_e  state;
  lpm_ctl_s    ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign irq_any = |irq_pend_i;

  lpm_fsm #(
    .OSC_SETTLE(OSC_SETTLE),
    .GRACE_CYC (GRACE_CYC),
    .W         (W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sleep_req(sleep_req_i),
    .deep_req (deep_req_i),
    .irq_any  (irq_any),
    .hw_rst   (hw_rst_i),
    .tmr_done (tmr_done),
    .state    (state),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  lpm_timer #(.W(W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  lpm_outdec u_dec (
    .state(state),
    .ctl  (ctl)
  );

  assign cpu_clk_en_o    = ctl.cpu_en;
  assign periph_clk_en_o = ctl.per_en;
  assign osc_en_o        = ctl.osc_en;
  assign core_rst_o      = ctl.core_rst;
  assign ram_wr_block_o  = ctl.ram_blk;
  assign sleep_o         = ctl.sleep;
  assign deep_o          = ctl.deep;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
  parameter int NIRQ       = 4,
  parameter int OSC_SETTLE = 8,
  parameter int GRACE_CYC  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_req_i,
  input logic            deep_req_i,
  input logic [NIRQ-1:0] irq_pend_i,
  input logic            hw_rst_i,
  input logic            cpu_clk_en_o,
  input logic            periph_clk_en_o,
  input logic            osc_en_o,
  input logic            core_rst_o,
  input logic            ram_wr_block_o,
  input logic            sleep_o,
  input logic            deep_o
);

  logic run_now;
  logic wake_now;
  logic grace_now;
  logic [31:0] wake_len_q;
  logic [31:0] grace_len_q;

  assign run_now   = cpu_clk_en_o & !core_rst_o & !ram_wr_block_o & !sleep_o & !deep_o;
  assign wake_now  = osc_en_o & core_rst_o & !cpu_clk_en_o;
  assign grace_now = ram_wr_block_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_len_q  <= '0;
      grace_len_q <= '0;
    end else begin
      wake_len_q  <= wake_now  ? wake_len_q + 1  : '0;
      grace_len_q <= grace_now ? grace_len_q + 1 : '0;
    end
  end

  p_sleep_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (!cpu_clk_en_o && periph_clk_en_o && osc_en_o));

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && sleep_req_i && !deep_req_i && !hw_rst_i) |=> sleep_o);

  p_deep_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deep_o |-> (!cpu_clk_en_o && !periph_clk_en_o && !osc_en_o));

  p_deep_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && deep_req_i && !hw_rst_i) |=> (deep_o && !sleep_o));

  p_irq_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && (|irq_pend_i) && !hw_rst_i) |=> (cpu_clk_en_o && !sleep_o));

  p_deep_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_o && !hw_rst_i) |=> deep_o);

  p_wake_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_o && hw_rst_i) |=> (osc_en_o && core_rst_o && !cpu_clk_en_o));

  p_settle_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_now && wake_len_q != 0) |-> (wake_len_q == OSC_SETTLE));

  p_grace_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grace_now && grace_len_q != 0) |-> (grace_len_q == GRACE_CYC && core_rst_o));

  p_grace_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_block_o |-> (cpu_clk_en_o && !core_rst_o));

  p_run_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_now && hw_rst_i) |=> (core_rst_o && cpu_clk_en_o && periph_clk_en_o));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_o && deep_o));

endmodule

bind lpm_seq lpm_seq_chk #(
  .NIRQ      (NIRQ),
  .OSC_SETTLE(OSC_SETTLE),
  .GRACE_CYC (GRACE_CYC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .sleep_req_i    (sleep_req_i),
  .deep_req_i     (deep_req_i),
  .irq_pend_i     (irq_pend_i),
  .hw_rst_i       (hw_rst_i),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o),
  .osc_en_o       (osc_en_o),
  .core_rst_o     (core_rst_o),
  .ram_wr_block_o (ram_wr_block_o),
  .sleep_o        (sleep_o),
  .deep_o         (deep_o)
);

// File: tb/sim_lpm_seq.sv
`timescale 1ns/1ps
module sim_lpm_seq;

  localparam int NIRQ       = 4;
  localparam int OSC_SETTLE = 8;
  localparam int GRACE_CYC  = 2;

  localparam int M_RUN = 0, M_SLP = 1, M_DEEP = 2, M_WAKE = 3, M_GRACE = 4, M_HOLD = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            sleep_req_i;
  logic            deep_req_i;
  logic [NIRQ-1:0] irq_pend_i;
  logic            hw_rst_i;
  logic            cpu_clk_en_o, periph_clk_en_o, osc_en_o, core_rst_o;
  logic            ram_wr_block_o, sleep_o, deep_o;

  int total = 0;
  int bad   = 0;
  int m_st  = M_HOLD;
  int m_cnt = 0;

  always #5 clk = ~clk;

  lpm_seq #(.NIRQ(NIRQ), .OSC_SETTLE(OSC_SETTLE), .GRACE_CYC(GRACE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .deep_req_i(deep_req_i),
    .irq_pend_i(irq_pend_i), .hw_rst_i(hw_rst_i), .cpu_clk_en_o(cpu_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o), .osc_en_o(osc_en_o), .core_rst_o(core_rst_o),
    .ram_wr_block_o(ram_wr_block_o), .sleep_o(sleep_o), .deep_o(deep_o)
  );

  // Expected output vector {cpu, periph, osc, core_rst, ram_blk, sleep, deep}
  function automatic logic [6:0] exp_out(int st);
    case (st)
      M_RUN:   return 7'b1110000;
      M_SLP:   return 7'b0110010;
      M_DEEP:  return 7'b0000001;
      M_WAKE:  return 7'b0011000;
      M_GRACE: return 7'b1110100;
      default: return 7'b1111000;
    endcase
  endfunction

  function automatic string st_tag(int st);
    case (st)
      M_RUN:   return "R1";
      M_SLP:   return "R2";
      M_DEEP:  return "R3";
      M_WAKE:  return "R7";
      M_GRACE: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic m_step(input bit sq, input bit dq, input logic [NIRQ-1:0] ir, input bit hr);
    case (m_st)
      M_RUN:   if (hr) m_st = M_HOLD; else if (dq) m_st = M_DEEP; else if (sq) m_st = M_SLP;
      M_SLP:   if (hr) begin m_st = M_GRACE; m_cnt = GRACE_CYC - 1; end
               else if (|ir) m_st = M_RUN;
      M_DEEP:  if (hr) begin m_st = M_WAKE; m_cnt = OSC_SETTLE - 1; end
      M_WAKE:  if (m_cnt == 0) m_st = hr ? M_HOLD : M_RUN; else m_cnt--;
      M_GRACE: if (m_cnt == 0) m_st = M_HOLD; else m_cnt--;
      default: if (!hr) m_st = M_RUN;
    endcase
  endtask

  task automatic check(input string tag);
    logic [6:0] act;
    logic [6:0] exp;
    act = {cpu_clk_en_o, periph_clk_en_o, osc_en_o, core_rst_o, ram_wr_block_o, sleep_o, deep_o};
    exp = exp_out(m_st);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs act=%b exp=%b (state %0d)", tag, act, exp, m_st);
    end
    total++;
    if (sleep_o && deep_o) begin
      bad++;
      $display("FAIL R10: both mode flags act=%b%b exp=0x", sleep_o, deep_o);
    end
  endtask

  // Drive at a falling edge, model the next rising edge, check at the following falling edge.
  task automatic cyc(input bit sq, input bit dq, input logic [NIRQ-1:0] ir, input bit hr,
                     input string tag);
    sleep_req_i = sq; deep_req_i = dq; irq_pend_i = ir; hw_rst_i = hr;
    m_step(sq, dq, ir, hr);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; sleep_req_i = 0; deep_req_i = 0; irq_pend_i = '0; hw_rst_i = 0;
    repeat (3) @(negedge clk);
    m_st = M_HOLD;
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_st = M_RUN;
    check("R1");

    // R2 then R5: light sleep, then interrupt on one line
    cyc(1, 0, '0, 0, "R2");
    cyc(0, 0, '0, 0, "R2");
    cyc(0, 0, 4'b1000, 0, "R5");
    // R4: both requests together
    cyc(1, 1, '0, 0, "R4");
    // R6: interrupts and requests in deep sleep
    cyc(0, 0, 4'b1111, 0, "R6");
    cyc(1, 1, 4'b0001, 0, "R6");
    // R7: one-cycle reset pulse, settle then run
    cyc(0, 0, '0, 1, "R7");
    for (int i = 0; i < OSC_SETTLE + 2; i++) cyc(0, 0, '0, 0, "R7");
    // R7: reset held past settle -> hold state
    cyc(0, 1, '0, 0, "R3");
    for (int i = 0; i < OSC_SETTLE + 3; i++) cyc(0, 0, '0, 1, "R7");
    cyc(0, 0, '0, 0, "R7");
    // R8: reset with interrupt in light sleep
    cyc(1, 0, '0, 0, "R2");
    cyc(0, 0, 4'b0010, 1, "R8");
    for (int i = 0; i < GRACE_CYC + 2; i++) cyc(0, 0, '0, 0, "R8");
    // R9: reset in run, held two cycles
    cyc(0, 0, '0, 1, "R9");
    cyc(0, 0, '0, 1, "R9");
    cyc(0, 0, '0, 0, "R9");
    cyc(0, 0, '0, 0, "R9");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit sq, dq, hr;
      logic [NIRQ-1:0] ir;
      sq = ($urandom % 100) < 12;
      dq = ($urandom % 100) < 6;
      hr = ($urandom % 100) < 7;
      ir = (($urandom % 100) < 25) ? NIRQ'($urandom) : '0;
      cyc(sq, dq, ir, hr, st_tag(m_st));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule